// File: doc/BRIEF.md
# I2C Bus Condition Monitor with Start Generator

This block observes the clock and data wires of a two-wire I2C bus. After passing each wire through a two-stage synchroniser, it recognises start and stop conditions and keeps them as sticky status flags. It also follows the position of the current bit inside each nine-clock frame. The frame position is published on dedicated ports, together with two slot markers. One marks the read/write clock (clock 8) of the first frame after a start, which is the address frame. The other marks the acknowledge clock (clock 9) of any frame. The counter advances only on real rising edges of the synchronised clock, so a slave that holds the clock low to insert wait time does not shift the count.

A small master-side generator sits beside the monitor. Software raises a request bit. The generator takes no action until a stop has been seen and both wires are high. It then pulls the data wire low while leaving the clock released, keeps that state for a programmable number of system clocks, and then pulls the clock low as well. At that point it clears the request and the stop flag, and keeps both wires held low until software hands the bus over with a release write. Drive outputs are active-high "pull low" enables for open-drain pads.

A four-entry register window gives access to control, status, hold time and frame position.

Generator states:
- `GEN_IDLE`: no request.
- `GEN_WAIT_FREE`: request pending, waiting for a free bus.
- `GEN_SDA_HOLD`: data wire pulled low.
- `GEN_SCL_PULL`: one cycle; the clock is pulled low and the request completes.
- `GEN_OWN`: both wires held low.

Generator transitions:
- IDLE→WAIT_FREE on a set request.
- WAIT_FREE→IDLE on a cancelled request.
- WAIT_FREE→SDA_HOLD when the stop flag is set and both wires are high.
- SDA_HOLD→SCL_PULL when the hold counter reaches zero.
- SCL_PULL→OWN unconditionally.
- OWN→IDLE on a release write.

Frame tracker states:
- `FRM_IDLE`: after reset or a stop.
- `FRM_ADDR`: first frame after any start.
- `FRM_DATA`: later frames.

Frame tracker transitions:
- A stop goes to IDLE from any state.
- A start goes to ADDR from any state.
- In ADDR, a rising edge that ends clock 9 moves to DATA.
- In DATA, a rising edge that ends clock 9 wraps the count to 1.

Top module: `i2c_cond_mon`

## Requirements
- R1: A falling data wire while the clock wire is high (both after synchronisation) sets the start flag, status bit 0 at register address 1. The flag is readable from the third clock edge after the wire change, and a detected start also clears the stop flag.
- R2: A rising data wire while the clock is high sets the stop flag (status bit 1) and clears the start flag.
- R3: Writing address 1 with bit 0 and/or bit 1 set clears the matching flag. A detection in the same cycle takes precedence over the clear.
- R4: After a start, `bit_pos` counts clock rising edges 1 to 9 and then wraps to 1 for the next frame. `ack_slot` (frame register bit 4) is high while `bit_pos` is 9. Rising edges outside a transfer leave `bit_pos` at 0.
- R5: Any start (including a repeated start) or any stop sets `bit_pos` to 0. `rw_slot` (frame register bit 5) is high only while `bit_pos` is 8 in the first frame after a start. The frame register at address 3 holds `bit_pos` in bits 3:0.
- R6: A clock low period of any length, such as a slave stretch, leaves `bit_pos` unchanged.
- R7: A request (control register, address 0, bit 0) drives nothing until the stop flag is 1 and both wires are high. A request set while the stop flag is 0 is honoured once a later stop arrives.
- R8: On a start request, the data wire is pulled low for HOLD+1 clocks while the clock is released, where HOLD is register address 2 with reset value 4. The clock is then also pulled low. At that point the request bit and the stop flag clear, and status bit 2 (owned) rises. Both wires stay low until a write to address 0 with bit 1 set releases them.
- R9: After reset the control register reads 0, the status register reads 0, the hold register reads 4, the frame register reads 0, and both drive outputs are 0.
- R10: Writing 0 to control bit 0 while the generator is waiting withdraws the request, so a later stop drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock wire level |
| sda_in | input | 1 | Raw data wire level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| scl_drive_low | output | 1 | Pull the clock wire low |
| sda_drive_low | output | 1 | Pull the data wire low |
| bit_pos | output | 4 | Bit position in the current frame, 0 when none |
| ack_slot | output | 1 | Acknowledge clock of the frame is active |
| rw_slot | output | 1 | Read/write clock of the address frame is active |

## Verification
Several stimulus patterns are used:
- A full address-plus-data transfer with a long stretch inside the data frame. This separates counting on clock edges from counting on elapsed time, and it shows the address-frame marking handing over to data framing at the wrap.
- A repeated start placed mid-frame. This shows that the counter and the address marking restart without a stop in between.
- Start requests issued in three situations: with no stop yet seen, withdrawn before a stop, and pending across an external stop. These separate stop-gated generation from immediate generation.
- A non-default hold value, measured in clocks. This confirms that the hold register sets the data-before-clock delay.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

    typedef enum logic [2:0] {
        GEN_IDLE,
        GEN_WAIT_FREE,
        GEN_SDA_HOLD,
        GEN_SCL_PULL,
        GEN_OWN
    } gen_state_t;

    typedef enum logic [1:0] {
        FRM_IDLE,
        FRM_ADDR,
        FRM_DATA
    } frm_state_t;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_STAT  = 2'd1;
    localparam logic [1:0] REG_HOLD  = 2'd2;
    localparam logic [1:0] REG_FRAME = 2'd3;

    localparam int CTRL_REQ_BIT = 0;
    localparam int CTRL_REL_BIT = 1;
    localparam int STAT_STA_BIT = 0;
    localparam int STAT_STO_BIT = 1;
    localparam int STAT_OWN_BIT = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] now,
    output logic [LINES-1:0] last
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              hist;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                hist  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                hist  <= chain[STAGES-1];
            end
        end

        assign now[g]  = chain[STAGES-1];
        assign last[g] = hist;
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_now,
    input  logic scl_last,
    input  logic sda_now,
    input  logic sda_last,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise
);

    logic clk_high_steady;

    assign clk_high_steady = scl_now & scl_last;
    assign start_ev = clk_high_steady & sda_last & ~sda_now;
    assign stop_ev  = clk_high_steady & ~sda_last & sda_now;
    assign scl_rise = scl_now & ~scl_last;

endmodule

// File: rtl/i2c_frame_track.sv
module i2c_frame_track
    import i2c_mon_pkg::*;
#(
    parameter int FRAME_BITS = 9,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             scl_rise,
    output logic [CNT_W-1:0] bit_pos,
    output logic             ack_slot,
    output logic             rw_slot
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] RW_POS   = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FIRST    = CNT_W'(1);

    frm_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= FRM_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (stop_ev) begin
            st_nx  = FRM_IDLE;
            cnt_nx = '0;
        end else if (start_ev) begin
            st_nx  = FRM_ADDR;
            cnt_nx = '0;
        end else if (scl_rise) begin
            unique case (st)
                FRM_IDLE: cnt_nx = '0;
                FRM_ADDR: begin
                    if (cnt == LAST_POS) begin
                        st_nx  = FRM_DATA;
                        cnt_nx = FIRST;
                    end else begin
                        cnt_nx = cnt + FIRST;
                    end
                end
                FRM_DATA: begin
                    if (cnt == LAST_POS) cnt_nx = FIRST;
                    else                 cnt_nx = cnt + FIRST;
                end
                default: begin
                    st_nx  = FRM_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_comb begin
        bit_pos  = cnt;
        ack_slot = (st != FRM_IDLE) && (cnt == LAST_POS);
        rw_slot  = (st == FRM_ADDR) && (cnt == RW_POS);
    end

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2c_mon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              stop_seen,
    input  logic              scl_now,
    input  logic              sda_now,
    input  logic              release_wr,
    input  logic [DATA_W-1:0] hold_cfg,
    output logic              sda_low,
    output logic              scl_low,
    output logic              done,
    output logic              owned
);

    gen_state_t        st, st_nx;
    logic [DATA_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= GEN_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nx;
            if (st == GEN_WAIT_FREE && st_nx == GEN_SDA_HOLD) cnt <= hold_cfg;
            else if (st == GEN_SDA_HOLD && cnt != '0)        cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            GEN_IDLE:      if (req) st_nx = GEN_WAIT_FREE;
            GEN_WAIT_FREE: begin
                if (!req)                                st_nx = GEN_IDLE;
                else if (stop_seen && scl_now && sda_now) st_nx = GEN_SDA_HOLD;
            end
            GEN_SDA_HOLD:  if (cnt == '0) st_nx = GEN_SCL_PULL;
            GEN_SCL_PULL:  st_nx = GEN_OWN;
            GEN_OWN:       if (release_wr) st_nx = GEN_IDLE;
            default:       st_nx = GEN_IDLE;
        endcase
    end

    always_comb begin
        sda_low = 1'b0;
        scl_low = 1'b0;
        done    = 1'b0;
        owned   = 1'b0;
        unique case (st)
            GEN_SDA_HOLD: sda_low = 1'b1;
            GEN_SCL_PULL: begin
                sda_low = 1'b1;
                scl_low = 1'b1;
                done    = 1'b1;
            end
            GEN_OWN: begin
                sda_low = 1'b1;
                scl_low = 1'b1;
                owned   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
    import i2c_mon_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          FRAME_BITS  = 9,
    parameter logic [7:0]  HOLD_RESET  = 8'd4,
    localparam int         CNT_W       = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [CNT_W-1:0]  bit_pos,
    output logic              ack_slot,
    output logic              rw_slot
);

    logic [1:0] line_now, line_last;
    logic       scl_s, sda_s;
    logic       start_ev, stop_ev, scl_rise;
    logic       start_flag, stop_flag, start_req;
    logic [DATA_W-1:0] hold_r;
    logic       gen_done, gen_owned;
    logic       wr_ctrl, wr_stat, wr_hold, release_wr;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({sda_in, scl_in}),
        .now  (line_now),
        .last (line_last)
    );

    assign scl_s = line_now[0];
    assign sda_s = line_now[1];

    i2c_cond_detect u_det (
        .scl_now (line_now[0]),
        .scl_last(line_last[0]),
        .sda_now (line_now[1]),
        .sda_last(line_last[1]),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .scl_rise(scl_rise)
    );

    i2c_frame_track #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .scl_rise(scl_rise),
        .bit_pos (bit_pos),
        .ack_slot(ack_slot),
        .rw_slot (rw_slot)
    );

    assign wr_ctrl    = reg_wr && (reg_addr == REG_CTRL);
    assign wr_stat    = reg_wr && (reg_addr == REG_STAT);
    assign wr_hold    = reg_wr && (reg_addr == REG_HOLD);
    assign release_wr = wr_ctrl && reg_wdata[CTRL_REL_BIT];

    i2c_start_gen #(.DATA_W(DATA_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (start_req),
        .stop_seen (stop_flag),
        .scl_now   (scl_s),
        .sda_now   (sda_s),
        .release_wr(release_wr),
        .hold_cfg  (hold_r),
        .sda_low   (sda_drive_low),
        .scl_low   (scl_drive_low),
        .done      (gen_done),
        .owned     (gen_owned)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
            start_req  <= 1'b0;
            hold_r     <= DATA_W'(HOLD_RESET);
        end else begin
            if (start_ev)                                start_flag <= 1'b1;
            else if (stop_ev)                            start_flag <= 1'b0;
            else if (wr_stat && reg_wdata[STAT_STA_BIT]) start_flag <= 1'b0;

            if (stop_ev)                                 stop_flag <= 1'b1;
            else if (start_ev || gen_done)               stop_flag <= 1'b0;
            else if (wr_stat && reg_wdata[STAT_STO_BIT]) stop_flag <= 1'b0;

            if (wr_ctrl)       start_req <= reg_wdata[CTRL_REQ_BIT];
            else if (gen_done) start_req <= 1'b0;

            if (wr_hold) hold_r <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: reg_rdata[CTRL_REQ_BIT] = start_req;
            REG_STAT: begin
                reg_rdata[STAT_STA_BIT] = start_flag;
                reg_rdata[STAT_STO_BIT] = stop_flag;
                reg_rdata[STAT_OWN_BIT] = gen_owned;
            end
            REG_HOLD: reg_rdata = hold_r;
            REG_FRAME: begin
                reg_rdata[CNT_W-1:0] = bit_pos;
                reg_rdata[CNT_W]     = ack_slot;
                reg_rdata[CNT_W+1]   = rw_slot;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_cond_mon_chk.sv
module i2c_cond_mon_chk #(
    parameter int FRAME_BITS = 9,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_ev,
    input logic             stop_ev,
    input logic             scl_rise,
    input logic             start_flag,
    input logic             stop_flag,
    input logic [CNT_W-1:0] bit_pos,
    input logic             sda_drive_low,
    input logic             scl_drive_low
);

    // R1
    start_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (start_flag && !stop_flag));

    // R2
    stop_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (stop_flag && !start_flag));

    // R4
    bit_pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= CNT_W'(FRAME_BITS));

    // R6
    no_edge_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise && !start_ev && !stop_ev) |=> $stable(bit_pos));

    // R5
    cond_clears_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev || stop_ev) |=> (bit_pos == '0));

    // R7
    gen_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> $past(stop_flag));

    // R8
    sda_before_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> $past(sda_drive_low));

endmodule

bind i2c_cond_mon i2c_cond_mon_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_ev     (start_ev),
    .stop_ev      (stop_ev),
    .scl_rise     (scl_rise),
    .start_flag   (start_flag),
    .stop_flag    (stop_flag),
    .bit_pos      (bit_pos),
    .sda_drive_low(sda_drive_low),
    .scl_drive_low(scl_drive_low)
);

// File: tb/sim_i2c_cond_mon.sv
`timescale 1ns/1ps
module sim_i2c_cond_mon;

    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_scl = 1'b1, ext_sda = 1'b1;
    logic       w_en = 1'b0;
    logic [1:0] w_addr = 2'd1;
    logic [7:0] w_data = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_drive_low, sda_drive_low, ack_slot, rw_slot;
    logic [3:0] bit_pos;
    logic       scl_line, sda_line;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign scl_line = ext_scl & ~scl_drive_low;
    assign sda_line = ext_sda & ~sda_drive_low;

    i2c_cond_mon u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_line),
        .sda_in       (sda_line),
        .reg_wr       (w_en),
        .reg_addr     (w_addr),
        .reg_wdata    (w_data),
        .reg_rdata    (reg_rdata),
        .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low),
        .bit_pos      (bit_pos),
        .ack_slot     (ack_slot),
        .rw_slot      (rw_slot)
    );

    // Behavioural reference model
    bit m_c1, m_c2, m_cq, m_d1, m_d2, m_dq;
    bit m_sta, m_sto, m_req;
    int m_hold, m_phase, m_pos, m_gst, m_gcnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_c1 = 1; m_c2 = 1; m_cq = 1; m_d1 = 1; m_d2 = 1; m_dq = 1;
            m_sta = 0; m_sto = 0; m_req = 0; m_hold = 4;
            m_phase = 0; m_pos = 0; m_gst = 0; m_gcnt = 0;
        end else begin
            bit lc, ld, e_st, e_sp, e_rise, done, wc, ws, wh;
            int gn;
            lc = ext_scl && !(m_gst == 3 || m_gst == 4);
            ld = ext_sda && !(m_gst >= 2);
            e_st = m_c2 && m_cq && m_dq && !m_d2;
            e_sp = m_c2 && m_cq && !m_dq && m_d2;
            e_rise = m_c2 && !m_cq;
            done = (m_gst == 3);
            wc = w_en && w_addr == 0;
            ws = w_en && w_addr == 1;
            wh = w_en && w_addr == 2;
            gn = m_gst;
            case (m_gst)
                0: if (m_req) gn = 1;
                1: if (!m_req) gn = 0;
                   else if (m_sto && m_c2 && m_d2) begin gn = 2; m_gcnt = m_hold; end
                2: if (m_gcnt == 0) gn = 3; else m_gcnt = m_gcnt - 1;
                3: gn = 4;
                default: if (wc && w_data[1]) gn = 0;
            endcase
            if (wc) m_req = w_data[0]; else if (done) m_req = 0;
            if (e_st) m_sta = 1; else if (e_sp) m_sta = 0; else if (ws && w_data[0]) m_sta = 0;
            if (e_sp) m_sto = 1; else if (e_st || done) m_sto = 0; else if (ws && w_data[1]) m_sto = 0;
            if (wh) m_hold = w_data;
            if (e_sp) begin m_phase = 0; m_pos = 0; end
            else if (e_st) begin m_phase = 1; m_pos = 0; end
            else if (e_rise && m_phase != 0) begin
                if (m_pos == 9) begin m_pos = 1; m_phase = 2; end
                else m_pos = m_pos + 1;
            end
            m_cq = m_c2; m_c2 = m_c1; m_c1 = lc;
            m_dq = m_d2; m_d2 = m_d1; m_d1 = ld;
            m_gst = gn;
        end
    end

    function automatic int model_rd(input logic [1:0] a);
        int ack, rw;
        ack = (m_phase != 0 && m_pos == 9);
        rw  = (m_phase == 1 && m_pos == 8);
        case (a)
            2'd0: return m_req;
            2'd1: return m_sta + 2 * m_sto + 4 * (m_gst == 4);
            2'd2: return m_hold;
            default: return m_pos + 16 * ack + 32 * rw;
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always begin
        @(posedge clk);
        #5;
        if (rst_n) begin
            chk("R1/R2/R3", "reg_rdata vs model", reg_rdata, model_rd(w_addr));
            chk("R4/R5/R6", "bit_pos vs model", bit_pos, m_pos);
            chk("R4", "ack_slot vs model", ack_slot, (m_phase != 0 && m_pos == 9));
            chk("R5", "rw_slot vs model", rw_slot, (m_phase == 1 && m_pos == 8));
            chk("R8", "sda_drive_low vs model", sda_drive_low, (m_gst >= 2));
            chk("R8", "scl_drive_low vs model", scl_drive_low, (m_gst >= 3));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        w_en = 1'b1; w_addr = a; w_data = d;
        @(negedge clk);
        w_en = 1'b0; w_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        w_addr = a;
        #2 v = reg_rdata;
        @(negedge clk);
        w_addr = 2'd1;
    endtask

    task automatic bus_start();
        ext_sda = 1'b0; cyc(HP);
        ext_scl = 1'b0; cyc(HP);
    endtask

    task automatic bus_bit(input bit b, input int stretch);
        ext_sda = b; cyc(HP + stretch);
        ext_scl = 1'b1; cyc(HP);
        ext_scl = 1'b0; cyc(2);
    endtask

    task automatic bus_stop();
        ext_sda = 1'b0; cyc(HP);
        ext_scl = 1'b1; cyc(HP);
        ext_sda = 1'b1; cyc(HP);
    endtask

    task automatic bus_rstart();
        ext_sda = 1'b1; cyc(HP);
        ext_scl = 1'b1; cyc(HP);
        ext_sda = 1'b0; cyc(HP);
        ext_scl = 1'b0; cyc(HP);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, lowcnt;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R9 reset values
        rd(2'd0, v); chk("R9", "ctrl after reset", v, 0);
        rd(2'd1, v); chk("R9", "status after reset", v, 0);
        rd(2'd2, v); chk("R9", "hold after reset", v, 4);
        rd(2'd3, v); chk("R9", "frame after reset", v, 0);
        chk("R9", "drives after reset", {scl_drive_low, sda_drive_low}, 0);

        // R7 request without a prior stop does nothing
        wr(2'd0, 8'h01);
        cyc(30);
        chk("R7", "sda drive with no stop seen", sda_drive_low, 0);
        rd(2'd0, v); chk("R7", "request still pending", v, 1);
        // R10 withdraw the request
        wr(2'd0, 8'h00);

        // Address frame, R1 start
        bus_start();
        rd(2'd1, v); chk("R1", "start flag after start", v, 1);
        chk("R5", "bit_pos after start", bit_pos, 0);
        for (int i = 0; i < 7; i++) bus_bit(i[0], 0);
        chk("R4", "bit_pos after 7 clocks", bit_pos, 7);
        bus_bit(1'b0, 0);
        chk("R5", "rw_slot on clock 8 of address frame", rw_slot, 1);
        bus_bit(1'b0, 0);
        chk("R4", "ack_slot on clock 9", ack_slot, 1);
        chk("R5", "rw_slot low on clock 9", rw_slot, 0);
        // Data frame with a stretch
        bus_bit(1'b1, 0);
        chk("R4", "wrap to 1 in data frame", bit_pos, 1);
        bus_bit(1'b0, 0);
        bus_bit(1'b1, 0);
        ext_sda = 1'b0; cyc(60);
        chk("R6", "bit_pos during long low clock", bit_pos, 3);
        bus_bit(1'b0, 0);
        chk("R6", "bit_pos after stretched clock", bit_pos, 4);
        for (int i = 0; i < 3; i++) bus_bit(1'b1, 0);
        bus_bit(1'b0, 0);
        chk("R5", "rw_slot low on clock 8 of data frame", rw_slot, 0);
        bus_bit(1'b0, 0);
        chk("R4", "ack_slot on data frame clock 9", ack_slot, 1);
        bus_stop();
        rd(2'd1, v); chk("R2", "status after stop", v, 2);
        chk("R5", "bit_pos after stop", bit_pos, 0);
        cyc(40);
        chk("R10", "withdrawn request drives nothing", {scl_drive_low, sda_drive_low}, 0);

        // R4 clock edges while idle
        ext_scl = 1'b0; cyc(HP); ext_scl = 1'b1; cyc(HP);
        chk("R4", "no count outside a transfer", bit_pos, 0);

        // R3 write-one-to-clear
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R3", "stop flag cleared by write", v, 0);

        // R5 repeated start mid-frame
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b1, 0);
        chk("R4", "bit_pos before repeated start", bit_pos, 4);
        bus_rstart();
        chk("R5", "bit_pos after repeated start", bit_pos, 0);
        rd(2'd1, v); chk("R1", "start flag after repeated start", v, 1);
        for (int i = 0; i < 8; i++) bus_bit(1'b0, 0);
        chk("R5", "rw_slot after repeated start", rw_slot, 1);
        rd(2'd3, v); chk("R5", "frame register rw and position", v, 32 + 8);
        bus_bit(1'b0, 0);
        rd(2'd3, v); chk("R4", "frame register ack and position", v, 16 + 9);
        bus_stop();
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R3", "start cleared, stop kept", v, 2);

        // R8 generation with hold of 5
        wr(2'd2, 8'd5);
        wr(2'd0, 8'h01);
        lowcnt = 0;
        for (int i = 0; i < 20 && !sda_drive_low; i++) @(negedge clk);
        for (int i = 0; i < 40 && !scl_drive_low; i++) begin
            if (sda_drive_low) lowcnt++;
            @(negedge clk);
        end
        chk("R8", "data-low clocks before clock pull", lowcnt, 6);
        cyc(10);
        rd(2'd0, v); chk("R8", "request cleared", v, 0);
        rd(2'd1, v); chk("R8", "status owned, stop cleared, start seen", v, 5);
        chk("R8", "both wires held low", {scl_drive_low, sda_drive_low}, 3);
        wr(2'd0, 8'h02);
        cyc(2);
        chk("R8", "release frees wires", {scl_drive_low, sda_drive_low}, 0);
        rd(2'd1, v); chk("R8", "owned bit clear after release", v, 1);

        // R7 request pending across a later stop
        wr(2'd0, 8'h01);
        cyc(30);
        chk("R7", "no drive while stop flag clear", sda_drive_low, 0);
        cyc(HP);
        bus_start();
        bus_stop();
        cyc(15);
        chk("R7", "generation after stop", {scl_drive_low, sda_drive_low}, 3);
        wr(2'd0, 8'h02);
        cyc(10);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule